// File: doc/BRIEF.md
# Transmit Symbol Data Request Timer

This block paces a serial data source that feeds a spread-spectrum transmitter. It runs on the chip clock and counts chips within each symbol. The symbol length is a programmable number of chips. One chip before each point where the transmitter needs a new data bit, the block raises a request to the source. On the clock edge that ends that chip, it captures the bit the source has placed on its serial input.

In the single-bit-per-symbol mode (BPSK), the block requests and captures one bit per symbol, at the symbol's last chip. In the two-bits-per-symbol mode (QPSK), it requests and captures twice per symbol: once at the chip before the midpoint and once at the last chip. The two bits are joined into an in-phase/quadrature pair.

After each complete symbol, the captured bit or pair is presented together with a one-cycle valid strobe. Dropping the transmit enable stops the timer. Raising it again starts a new symbol at chip 0.

Top module: `tx_symbol_req_timer`

## Requirements
- R1: While reset is asserted, and after it with transmit enable low, `req`, `sym_valid`, `i_bit` and `q_bit` are all 0.
- R2: The effective symbol length N is `chips_per_sym` with bit 0 cleared, and it is raised to 4 when that value is below 4. For example, 7 gives 6, 3 gives 4 and 1 gives 4.
- R3: With `bpsk_mode` = 1 and enable high, `req` is high only during chip N-1 of each symbol. Chips are numbered 0 to N-1 from the first chip after enable rises.
- R4: In BPSK mode, the `tx_bit` value present at the clock edge that ends chip N-1 appears on `i_bit` in the following cycle, and `sym_valid` is high in that same cycle.
- R5: With `bpsk_mode` = 0 and enable high, `req` is high only during chips N/2-1 and N-1 of each symbol.
- R6: In QPSK mode, the bit captured at the end of chip N/2-1 goes to `i_bit` and the bit captured at the end of chip N-1 goes to `q_bit`. Both appear together in the cycle after chip N-1, with `sym_valid` high for exactly that one cycle.
- R7: `req` is high for exactly one chip and falls immediately after the edge that captures the data bit.
- R8: While enable is low, `req` is 0 and the chip count is held at 0. `sym_valid` is 0 in the cycle after a disabled edge. When enable returns high, the next symbol starts at chip 0.
- R9: In BPSK mode, `q_bit` is driven to 0 whenever a symbol is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; requests repeat while high |
| bpsk_mode | input | 1 | 1 = one bit per symbol, 0 = two bits per symbol |
| chips_per_sym | input | CPS_W | Requested chips per symbol |
| tx_bit | input | 1 | Serial data bit from the source |
| req | output | 1 | Data request, one chip ahead of the capture |
| i_bit | output | 1 | Captured in-phase bit (sole bit in BPSK) |
| q_bit | output | 1 | Captured quadrature bit (0 in BPSK) |
| sym_valid | output | 1 | One-cycle strobe when a symbol's bits are presented |

## Verification
The bench walks every chip of several symbols in both modes and compares `req` against the expected chip positions. A timer that was off by one would raise the request on the capture edge or one chip too early, and the per-chip comparison exposes either error. Odd and undersized symbol lengths test the clamp, because a design that used the raw count would put the QPSK midpoint on the wrong chip. The bench also changes the data bit on every chip, so swapping I and Q, or capturing one chip late, puts the wrong bit on an output. Disabling partway through a symbol and then re-enabling checks that a stale count is not carried into the new symbol.

// File: rtl/tx_symbol_req_timer.sv
module tx_symbol_req_timer #(
  parameter int CPS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             bpsk_mode,
  input  logic [CPS_W-1:0] chips_per_sym,
  input  logic             tx_bit,
  output logic             req,
  output logic             i_bit,
  output logic             q_bit,
  output logic             sym_valid
);

  localparam logic [CPS_W-1:0] MIN_CPS = CPS_W'(4);

  logic [CPS_W-1:0] even_cps, n_eff, last_chip, mid_chip, cnt;
  logic             at_end, at_mid, i_hold;

  assign even_cps  = {chips_per_sym[CPS_W-1:1], 1'b0};
  assign n_eff     = (even_cps < MIN_CPS) ? MIN_CPS : even_cps;
  assign last_chip = n_eff - CPS_W'(1);
  assign mid_chip  = (n_eff >> 1) - CPS_W'(1);
  assign at_end    = cnt >= last_chip;
  assign at_mid    = cnt == mid_chip;
  assign req       = tx_en && (at_end || (!bpsk_mode && at_mid));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      sym_valid <= 1'b0;
      i_hold    <= 1'b0;
      i_bit     <= 1'b0;
      q_bit     <= 1'b0;
    end else begin
      sym_valid <= tx_en && at_end;
      if (!tx_en)
        cnt <= '0;
      else
        cnt <= at_end ? '0 : cnt + CPS_W'(1);
      if (tx_en && !bpsk_mode && at_mid)
        i_hold <= tx_bit;
      if (tx_en && at_end) begin
        if (bpsk_mode) begin
          i_bit <= tx_bit;
          q_bit <= 1'b0;
        end else begin
          i_bit <= i_hold;
          q_bit <= tx_bit;
        end
      end
    end
  end

  AST_REQ_ONE_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req); // R7
  AST_VALID_FOLLOWS_END: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && at_end) |=> sym_valid); // R4
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> !sym_valid); // R6
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !req); // R8
  AST_IDLE_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (cnt == '0 && !sym_valid)); // R8
  AST_BPSK_Q_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && at_end && bpsk_mode) |=> !q_bit); // R9
  AST_NEFF_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (n_eff >= MIN_CPS) && !n_eff[0]); // R2

endmodule

// File: tb/test_tx_symbol_req_timer.sv
module test_tx_symbol_req_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CPS_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0, bpsk_mode = 1'b1, tx_bit = 1'b0;
  logic [CPS_W-1:0] chips_per_sym = 8'd8;
  logic req, i_bit, q_bit, sym_valid;
  int n_checks = 0, n_fails = 0;
  logic [7:0] pat = 8'hA5;
  bit done = 0;

  tx_symbol_req_timer #(.CPS_W(CPS_W)) i_tx_symbol_req_timer (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bpsk_mode(bpsk_mode),
    .chips_per_sym(chips_per_sym), .tx_bit(tx_bit), .req(req),
    .i_bit(i_bit), .q_bit(q_bit), .sym_valid(sym_valid));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_case(input bit bpsk, input int cps, input int nsym, input string name);
    int n, total;
    bit ei, eq, hold, er;
    n = cps & ~1;
    if (n < 4) n = 4;
    total = n * nsym;
    ei = 0; eq = 0; hold = 0;
    bpsk_mode = bpsk;
    chips_per_sym = CPS_W'(cps);
    tx_en = 1'b1;
    for (int k = 0; k <= total; k++) begin
      int pos;
      pos = k % n;
      #1;
      er = (pos == n-1) || (!bpsk && pos == n/2-1);
      chk(req == er, $sformatf("%s req chip %0d %s", name, pos, er ? (bpsk ? "R3" : "R5") : "R7"), req, er);
      if (k > 0 && pos == 0) begin
        chk(sym_valid == 1'b1, {name, " strobe R4"}, sym_valid, 1);
        chk(i_bit == ei, {name, bpsk ? " i_bit R4" : " i_bit R6"}, i_bit, ei);
        chk(q_bit == eq, {name, bpsk ? " q_bit R9" : " q_bit R6"}, q_bit, eq);
      end else begin
        chk(sym_valid == 1'b0, {name, " strobe idle R6"}, sym_valid, 0);
      end
      if (k == total) break;
      tx_bit = pat[0];
      if (bpsk && pos == n-1) begin ei = tx_bit; eq = 0; end
      if (!bpsk && pos == n/2-1) hold = tx_bit;
      if (!bpsk && pos == n-1) begin ei = hold; eq = tx_bit; end
      pat = {pat[6:0], pat[7] ^ pat[5] ^ pat[4] ^ pat[3]};
      @(posedge clk); @(negedge clk);
    end
    tx_en = 1'b0;
    #1;
    chk(req == 1'b0, {name, " req after disable R8"}, req, 0);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic test_reset();
    #1;
    chk(req == 0 && sym_valid == 0 && i_bit == 0 && q_bit == 0, "reset outputs R1",
        {req, sym_valid, i_bit, q_bit}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(req == 0 && sym_valid == 0 && i_bit == 0 && q_bit == 0, "idle after reset R1",
        {req, sym_valid, i_bit, q_bit}, 0);
  endtask

  task automatic test_bpsk();
    run_case(1'b1, 8, 4, "bpsk n8");
    run_case(1'b1, 5, 3, "bpsk n5");
  endtask

  task automatic test_qpsk();
    run_case(1'b0, 8, 4, "qpsk n8");
    run_case(1'b0, 12, 3, "qpsk n12");
  endtask

  task automatic test_clamp();
    run_case(1'b0, 7, 3, "R2 clamp cps7");
    run_case(1'b0, 3, 3, "R2 clamp cps3");
    run_case(1'b1, 1, 3, "R2 clamp cps1");
  endtask

  task automatic test_disable();
    bpsk_mode = 1'b1; chips_per_sym = 8'd8;
    tx_en = 1'b1;
    repeat (5) begin @(posedge clk); @(negedge clk); end
    tx_en = 1'b0;
    for (int j = 0; j < 10; j++) begin
      #1;
      chk(req == 1'b0, "req while disabled R8", req, 0);
      @(posedge clk); @(negedge clk);
      chk(sym_valid == 1'b0, "strobe while disabled R8", sym_valid, 0);
    end
    run_case(1'b1, 8, 2, "R8 restart bpsk");
    tx_en = 1'b1; bpsk_mode = 1'b0;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    tx_en = 1'b0;
    @(posedge clk); @(negedge clk);
    run_case(1'b0, 8, 2, "R8 restart qpsk");
  endtask

  initial begin
    @(negedge clk);
    test_reset();
    test_bpsk();
    test_qpsk();
    test_clamp();
    test_disable();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule